// File: doc/BRIEF.md
# Four-Level Nesting Interrupt Arbiter

This block arbitrates up to sixteen interrupt sources for a small processor core. Each source presents a pending flag, has its own enable bit, and carries a two-level-bit priority assembled from two separate configuration words: one word supplies the low bit of every source's level, the other supplies the high bit. A single global enable gates every source at once. Among the eligible sources the block picks the one at the highest level, and the lowest-numbered source wins a tie. It presents that source's index and level to the core together with a request flag.

The block keeps a small stack of the levels currently being serviced. A request is raised only when nothing is in service, or when the winning level is strictly above the level on top of the stack. An equal or lower level waits. An acknowledge from the core pushes the granted level. A return strobe pops the stack. Several sources may be given the same vector in the core's table; software then reads the individual pending flags to find the cause.

The request/acknowledge pair behaves as a valid/ready handshake with one difference. The request is combinational on the current pending, enable, priority and stack state, so the offered index may change from one cycle to the next while the core withholds the acknowledge. Nothing is queued inside the block: a grant takes the index and level offered in the acknowledge cycle. A source that drops its pending flag before the grant is simply no longer offered.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the service stack is empty (svc_depth 0, svc_lvl 0), and with no pending source irq_req is 0.
- R2: A source whose bit in src_en is 0 is never offered, whatever its pending flag or level.
- R3: While glb_en is 0, irq_req is 0 in the same cycle, with no register delay.
- R4: Source i has level {prio_hi[i], prio_lo[i]}: prio_hi supplies bit 1 and prio_lo supplies bit 0, so the levels run from 0 (lowest) to 3 (highest).
- R5: When eligible sources sit at different levels, the source at the highest level is offered.
- R6: When several eligible sources share the highest level, the lowest-numbered one is offered.
- R7: With the stack non-empty, irq_req is 1 only if the winning level is strictly greater than svc_lvl. An equal or lower level raises no request.
- R8: irq_ack in a cycle where irq_req is 1 pushes irq_lvl. From the next cycle svc_depth is one higher and svc_lvl equals the granted level.
- R9: irq_ret pops one level off the stack. irq_ret with an empty stack leaves svc_depth at 0.
- R10: irq_ack in a cycle where irq_req is 0 leaves the stack unchanged.
- R11: If irq_ack and irq_ret arrive in the same cycle, only the pop takes place and the acknowledge is dropped.
- R12: While irq_req is 1, irq_vec is the index of the offered source and irq_lvl is that source's level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pend | input | 16 | Pending flag per source |
| src_en | input | 16 | Enable bit per source |
| glb_en | input | 1 | Global enable for all sources |
| prio_lo | input | 16 | Level bit 0 per source |
| prio_hi | input | 16 | Level bit 1 per source |
| irq_ack | input | 1 | Core accepts the offered request |
| irq_ret | input | 1 | Core returns from the current handler |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 4 | Index of the offered source |
| irq_lvl | output | 2 | Level of the offered source |
| svc_depth | output | 3 | Number of levels in service |
| svc_lvl | output | 2 | Level on top of the service stack, 0 when empty |

## Verification
The bench targets the points where an arbiter of this kind usually goes wrong.

- Level ties: a scan that keeps the last match instead of the first would offer a higher-numbered source.
- Level encoding: swapping the two priority words would rank a level-1 source above a level-2 source.
- Equal-level preemption: a design that compares with greater-or-equal would let a second handler at the same level nest.
- Acknowledge without a request, and acknowledge together with return: a careless stack would grow on a stray strobe, or would push and pop in one cycle and corrupt the top entry.
- Global enable: dropping it must kill the request at once rather than one cycle later.

Long random runs also drive the stack to its full depth of four and back to empty.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int LVL_W = 2;
  localparam int NLVL  = 1 << LVL_W;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_level_scan.sv
// Finds the highest level among eligible sources and the lowest index at it.
module irq_level_scan
  import prio_irq_pkg::*;
#(
  parameter int NSRC = 16,
  localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] elig,
  input  lvl_t            src_lvl [NSRC],
  output logic            any_elig,
  output logic [IDW-1:0]  win_idx,
  output lvl_t            win_lvl
);
  logic [NSRC-1:0] lvl_hit [NLVL];
  logic [NLVL-1:0] lvl_any;
  logic [NSRC-1:0] sel;

  for (genvar gl = 0; gl < NLVL; gl++) begin : g_lvl
    for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
      assign lvl_hit[gl][gi] = elig[gi] && (src_lvl[gi] == lvl_t'(gl));
    end
    assign lvl_any[gl] = |lvl_hit[gl];
  end

  // Ascending scan: the highest populated level is the last one kept.
  always_comb begin
    win_lvl = '0;
    sel     = lvl_hit[0];
    for (int l = 0; l < NLVL; l++) begin
      if (lvl_any[l]) begin
        win_lvl = lvl_t'(l);
        sel     = lvl_hit[l];
      end
    end
  end

  // Descending scan: the lowest index is the last one kept.
  always_comb begin
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (sel[i]) win_idx = IDW'(i);
    end
  end

  assign any_elig = |elig;
endmodule

// File: rtl/irq_svc_stack.sv
// Stack of in-service levels; a pop beats a push in the same cycle.
module irq_svc_stack
  import prio_irq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  lvl_t          push_lvl,
  output logic [DW-1:0] depth,
  output lvl_t          top_lvl
);
  lvl_t          ent_q [DEPTH];
  logic [DW-1:0] cnt_q;
  logic          do_pop;
  logic          do_push;

  assign do_pop  = pop && (cnt_q != '0);
  assign do_push = push && !pop && (cnt_q != DW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (do_pop)  cnt_q <= cnt_q - 1'b1;
    else if (do_push) cnt_q <= cnt_q + 1'b1;
  end

  for (genvar ge = 0; ge < DEPTH; ge++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                              ent_q[ge] <= '0;
      else if (do_push && cnt_q == DW'(ge))    ent_q[ge] <= push_lvl;
    end
  end

  always_comb begin
    top_lvl = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (cnt_q == DW'(e + 1)) top_lvl = ent_q[e];
    end
  end

  assign depth = cnt_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NSRC = 16,
  localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int SVC_DEPTH = NLVL,
  localparam int DW = $clog2(SVC_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_pend,
  input  logic [NSRC-1:0] src_en,
  input  logic            glb_en,
  input  logic [NSRC-1:0] prio_lo,
  input  logic [NSRC-1:0] prio_hi,
  input  logic            irq_ack,
  input  logic            irq_ret,
  output logic            irq_req,
  output logic [IDW-1:0]  irq_vec,
  output logic [1:0]      irq_lvl,
  output logic [DW-1:0]   svc_depth,
  output logic [1:0]      svc_lvl
);
  lvl_t            src_lvl [NSRC];
  logic [NSRC-1:0] elig;
  logic            any_elig;
  logic [IDW-1:0]  win_idx;
  lvl_t            win_lvl;
  logic [DW-1:0]   depth;
  lvl_t            top_lvl;
  logic            may_preempt;
  logic            grant;

  // Level bit 1 from the high word, bit 0 from the low word.
  for (genvar gi = 0; gi < NSRC; gi++) begin : g_lvl
    assign src_lvl[gi] = {prio_hi[gi], prio_lo[gi]};
  end

  assign elig = src_pend & src_en & {NSRC{glb_en}};

  irq_level_scan #(.NSRC(NSRC)) u_scan (
    .elig     (elig),
    .src_lvl  (src_lvl),
    .any_elig (any_elig),
    .win_idx  (win_idx),
    .win_lvl  (win_lvl)
  );

  assign may_preempt = (depth == '0) || (win_lvl > top_lvl);
  assign irq_req     = any_elig && may_preempt;
  assign grant       = irq_ack && irq_req;

  irq_svc_stack #(.DEPTH(SVC_DEPTH)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (grant),
    .pop      (irq_ret),
    .push_lvl (win_lvl),
    .depth    (depth),
    .top_lvl  (top_lvl)
  );

  assign irq_vec   = win_idx;
  assign irq_lvl   = win_lvl;
  assign svc_depth = depth;
  assign svc_lvl   = top_lvl;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int NSRC = 16,
  parameter int IDW  = 4,
  parameter int DW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_pend,
  input logic [NSRC-1:0] src_en,
  input logic            glb_en,
  input logic            irq_ack,
  input logic            irq_ret,
  input logic            irq_req,
  input logic [IDW-1:0]  irq_vec,
  input logic [1:0]      irq_lvl,
  input logic [DW-1:0]   svc_depth,
  input logic [1:0]      svc_lvl
);
  assert_glb_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> !irq_req);

  assert_offer_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (src_pend[irq_vec] && src_en[irq_vec]));

  assert_strict_preempt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && svc_depth != '0) |-> (irq_lvl > svc_lvl));

  assert_push_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && !irq_ret) |=>
      (svc_depth == $past(svc_depth) + 1'b1) && (svc_lvl == $past(irq_lvl)));

  assert_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && svc_depth != '0) |=> (svc_depth == $past(svc_depth) - 1'b1));

  assert_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ret && svc_depth == '0) |=> (svc_depth == '0));

  assert_stray_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_req && !irq_ret) |=> $stable(svc_depth));

  assert_depth_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    svc_depth <= DW'(4));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NSRC(NSRC), .IDW(IDW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .src_en(src_en),
  .glb_en(glb_en), .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req),
  .irq_vec(irq_vec), .irq_lvl(irq_lvl), .svc_depth(svc_depth), .svc_lvl(svc_lvl)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_pend = '0, src_en = '0, prio_lo = '0, prio_hi = '0;
  logic        glb_en = 1'b0, irq_ack = 1'b0, irq_ret = 1'b0;
  logic        irq_req;
  logic [3:0]  irq_vec;
  logic [1:0]  irq_lvl, svc_lvl;
  logic [2:0]  svc_depth;

  int n_cmp = 0;
  int n_bad = 0;
  int stk[$];
  string tag = "R1";

  always #10 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .src_en(src_en),
    .glb_en(glb_en), .prio_lo(prio_lo), .prio_hi(prio_hi),
    .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req),
    .irq_vec(irq_vec), .irq_lvl(irq_lvl), .svc_depth(svc_depth),
    .svc_lvl(svc_lvl)
  );

  // Reference: pick the highest level, first index wins a tie.
  int m_idx, m_lvl;
  bit m_req;
  task automatic model_eval();
    m_idx = -1; m_lvl = -1;
    for (int i = 0; i < 16; i++) begin
      if (glb_en && src_pend[i] && src_en[i]) begin
        int l = (prio_hi[i] ? 2 : 0) + (prio_lo[i] ? 1 : 0);
        if (l > m_lvl) begin m_lvl = l; m_idx = i; end
      end
    end
    m_req = (m_idx >= 0) && (stk.size() == 0 || m_lvl > stk[$]);
  endtask

  task automatic cmp(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    model_eval();
    cmp("irq_req", irq_req, m_req);
    if (m_req) begin
      cmp("irq_vec", irq_vec, m_idx);
      cmp("irq_lvl", irq_lvl, m_lvl);
    end
    cmp("svc_depth", svc_depth, stk.size());
    cmp("svc_lvl", svc_lvl, stk.size() == 0 ? 0 : stk[$]);
  endtask

  task automatic model_clock();
    if (!rst_n) stk.delete();
    else if (irq_ret) begin
      if (stk.size() != 0) void'(stk.pop_back());
    end else if (irq_ack && m_req) stk.push_back(m_lvl);
  endtask

  task automatic cyc(input string t, input logic [15:0] p, input logic [15:0] e,
                     input logic g, input logic [15:0] lo, input logic [15:0] hi,
                     input logic a, input logic r);
    @(negedge clk);
    tag = t;
    src_pend = p; src_en = e; glb_en = g; prio_lo = lo; prio_hi = hi;
    irq_ack = a; irq_ret = r;
    #5;
    compare_all();
    @(posedge clk);
    model_clock();
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog all-reqs actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    cyc("R1", 16'h0, 16'h0, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0);
    cyc("R1", 16'h0, 16'h0, 1'b0, 16'h0, 16'h0, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    cyc("R1", 16'h0, 16'hFFFF, 1'b1, 16'h0, 16'h0, 1'b0, 1'b0);
    // R6 / R12: equal levels, lowest index offered
    cyc("R6", 16'h0030, 16'hFFFF, 1'b1, 16'h0, 16'h0, 1'b0, 1'b0);
    cyc("R12", 16'h8000, 16'hFFFF, 1'b1, 16'h0, 16'h0, 1'b0, 1'b0);
    // R2: disabled source skipped
    cyc("R2", 16'h0030, 16'hFFEF, 1'b1, 16'h0, 16'h0, 1'b0, 1'b0);
    cyc("R2", 16'h0010, 16'hFFEF, 1'b1, 16'h0, 16'hFFFF, 1'b1, 1'b0);
    // R3: global enable kills request at once
    cyc("R3", 16'hFFFF, 16'hFFFF, 1'b0, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0);
    // R4 / R5: source 2 level 2 (hi) beats source 1 level 1 (lo)
    cyc("R4", 16'h0006, 16'hFFFF, 1'b1, 16'h0002, 16'h0004, 1'b0, 1'b0);
    cyc("R5", 16'h0107, 16'hFFFF, 1'b1, 16'h0103, 16'h0104, 1'b0, 1'b0);
    // R10: stray acknowledge
    cyc("R10", 16'h0, 16'hFFFF, 1'b1, 16'h0, 16'h0, 1'b1, 1'b0);
    cyc("R10", 16'h0, 16'hFFFF, 1'b1, 16'h0, 16'h0, 1'b0, 1'b0);
    // R8: grant source 3 at level 1
    cyc("R8", 16'h0008, 16'hFFFF, 1'b1, 16'h0008, 16'h0, 1'b1, 1'b0);
    cyc("R8", 16'h0, 16'hFFFF, 1'b1, 16'h0, 16'h0, 1'b0, 1'b0);
    // R7: equal and lower levels wait
    cyc("R7", 16'h0001, 16'hFFFF, 1'b1, 16'h0001, 16'h0, 1'b0, 1'b0);
    cyc("R7", 16'h0040, 16'hFFFF, 1'b1, 16'h0, 16'h0, 1'b1, 1'b0);
    // R7: level 3 preempts
    cyc("R7", 16'h0200, 16'hFFFF, 1'b1, 16'h0200, 16'h0200, 1'b1, 1'b0);
    cyc("R7", 16'h0200, 16'hFFFF, 1'b1, 16'h0200, 16'h0200, 1'b1, 1'b0);
    // R11: ack with return, nothing offered, then with a live request
    cyc("R11", 16'h0200, 16'hFFFF, 1'b1, 16'h0200, 16'h0200, 1'b1, 1'b1);
    cyc("R11", 16'h0200, 16'hFFFF, 1'b1, 16'h0200, 16'h0200, 1'b1, 1'b1);
    cyc("R11", 16'h0, 16'hFFFF, 1'b1, 16'h0, 16'h0, 1'b0, 1'b0);
    // R9: return on empty stack
    cyc("R9", 16'h0, 16'hFFFF, 1'b1, 16'h0, 16'h0, 1'b0, 1'b1);
    cyc("R9", 16'h0, 16'hFFFF, 1'b1, 16'h0, 16'h0, 1'b0, 1'b0);
    // R8: fill all four levels, then unwind (R9)
    for (int k = 0; k < 4; k++) begin
      logic [15:0] lo = (k[0]) ? 16'hFFFF : 16'h0;
      logic [15:0] hi = (k[1]) ? 16'hFFFF : 16'h0;
      cyc("R8", 16'h0F00, 16'hFFFF, 1'b1, lo, hi, 1'b1, 1'b0);
    end
    cyc("R7", 16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0);
    for (int k = 0; k < 5; k++)
      cyc("R9", 16'h0, 16'hFFFF, 1'b1, 16'h0, 16'h0, 1'b0, 1'b1);
    // Random mix covering R2-R12
    for (int n = 0; n < 4000; n++) begin
      cyc("R5", 16'($urandom), 16'($urandom) | 16'($urandom),
          ($urandom % 8) != 0, 16'($urandom), 16'($urandom),
          ($urandom % 3) == 0, ($urandom % 5) == 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule